// File: doc/BRIEF.md
# Dual-Lane Programmable-Length Delay Line

This block delays an 8-bit stream by a programmable number of clock cycles. The byte is split into two 4-bit lanes. Each lane shifts its nibble through a chain of 17 stage registers, and a tap multiplexer then loads one of stages 2 to 17 into a lane output register. The tap is set by a 4-bit length code, so a lane delays its data by the code plus 3 cycles, which gives 3 to 18 cycles.

A control register captures the length code and a lane-pinning bit on every rising clock edge. When the pinning bit is 0, both lanes follow the code. When it is 1, the upper lane always takes stage 17, so its delay is 18 cycles, and the lower lane still follows the code. Changing either control input changes only the tap choice and never the contents of the stage chains. A synchronous active-high reset clears the control register, the chains and the outputs.

Top module: `dl_delay_line`

## Requirements
- R1: With `pin_upper` = 0 in the control register, a lower nibble (`din[3:0]`) sampled on edge n appears on `dout[3:0]` right after edge n+L+2, where L is the registered length code (0 to 15).
- R2: With `pin_upper` = 0, the upper nibble (`din[7:4]`) follows the same L+3 cycle delay on `dout[7:4]`.
- R3: With `pin_upper` = 1 in the control register, `dout[7:4]` shows the upper nibble sampled 17 edges earlier (an 18-cycle delay) whatever L is, while the lower lane keeps following L.
- R4: `len_code` and `pin_upper` are captured on a rising edge and steer the taps from the next edge on. The edge that captures a new value still uses the old tap.
- R5: A change of `len_code` or `pin_upper` while data is in flight leaves every stage register intact. After the change, the output shows data from the new tap position with no loss or corruption.
- R6: The two lanes are independent. Data on one nibble never shows up on the other lane's output.
- R7: A rising edge with `rst` = 1 clears the control register, all stage registers and `dout` to 0. Data sampled on or before that edge never reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | Lower lane in bits 3:0, upper lane in bits 7:4 |
| len_code | input | 4 | Length code L; delay is L+3 cycles |
| pin_upper | input | 1 | 1 pins the upper lane to 18 cycles |
| dout | output | 8 | Delayed data, lanes in the same bit positions as `din` |

## Verification
On a single edge the control register can capture a new length code while the tap multiplexers still load the output registers using the previous code, and the chains keep shifting. The bench provokes this by changing `len_code` and `pin_upper` in the middle of a continuous stream, several times in a row, including single-cycle changes and switches between the shortest and longest taps. Each output is judged against a history-based model that keeps every sampled input byte and control value. That model uses, for each edge, the control value captured one edge earlier, and it discards data that was cleared by a reset.

// File: rtl/dl_pkg.sv
package dl_pkg;

    parameter int DL_LANE_W    = 4;
    parameter int DL_NUM_LANES = 2;
    parameter int DL_CODE_W    = 4;

    // Delay of a lane = code + 3; shortest tap is stage 2 (index 1).
    localparam int DL_FIRST_TAP = 1;

    function automatic int chain_len(input int code_w);
        return DL_FIRST_TAP + (1 << code_w);
    endfunction

    typedef struct packed {
        logic                 pin_upper;
        logic [DL_CODE_W-1:0] len;
    } dl_ctrl_t;

endpackage

// File: rtl/dl_ctrl_reg.sv
module dl_ctrl_reg
    import dl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DL_CODE_W-1:0] len_in,
    input  logic                 pin_in,
    output dl_ctrl_t             ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q.len       <= len_in;
            ctrl_q.pin_upper <= pin_in;
        end
    end

endmodule

// File: rtl/dl_lane.sv
module dl_lane #(
    parameter int LANE_W    = 4,
    parameter int CODE_W    = 4,
    parameter int CHAIN_LEN = dl_pkg::chain_len(CODE_W)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [LANE_W-1:0]                  d,
    input  logic [CODE_W-1:0]                  code,
    output logic [CHAIN_LEN-1:0][LANE_W-1:0]   stages,
    output logic [LANE_W-1:0]                  q
);

    localparam int IDX_W = $clog2(CHAIN_LEN);

    logic [CHAIN_LEN-1:0][LANE_W-1:0] stage_q;
    logic [IDX_W-1:0]                 tap_idx;
    logic [LANE_W-1:0]                tap_val;

    // Shift chain: stage_q[0] is the first stage.
    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[CHAIN_LEN-2:0], d};
        end
    end

    always_comb begin
        tap_idx = IDX_W'(code) + IDX_W'(dl_pkg::DL_FIRST_TAP);
        tap_val = stage_q[tap_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= tap_val;
        end
    end

    assign stages = stage_q;

endmodule

// File: rtl/dl_delay_line.sv
module dl_delay_line
    import dl_pkg::*;
#(
    parameter int LANE_W    = DL_LANE_W,
    parameter int NUM_LANES = DL_NUM_LANES,
    localparam int DATA_W   = LANE_W * NUM_LANES,
    localparam int CHAIN_LEN = chain_len(DL_CODE_W)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DATA_W-1:0]    din,
    input  logic [DL_CODE_W-1:0] len_code,
    input  logic                 pin_upper,
    output logic [DATA_W-1:0]    dout
);

    dl_ctrl_t ctrl_q;
    logic [NUM_LANES-1:0][CHAIN_LEN-1:0][LANE_W-1:0] lane_stages;

    dl_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .len_in (len_code),
        .pin_in (pin_upper),
        .ctrl_q (ctrl_q)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [DL_CODE_W-1:0] lane_code;

        if (g == NUM_LANES - 1) begin : g_pinnable
            assign lane_code = ctrl_q.pin_upper ? '1 : ctrl_q.len;
        end else begin : g_plain
            assign lane_code = ctrl_q.len;
        end

        dl_lane #(
            .LANE_W    (LANE_W),
            .CODE_W    (DL_CODE_W),
            .CHAIN_LEN (CHAIN_LEN)
        ) u_lane (
            .clk    (clk),
            .rst    (rst),
            .d      (din[g*LANE_W +: LANE_W]),
            .code   (lane_code),
            .stages (lane_stages[g]),
            .q      (dout[g*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/dl_delay_line_chk.sv
module dl_delay_line_chk
    import dl_pkg::*;
#(
    parameter int LANE_W    = DL_LANE_W,
    parameter int NUM_LANES = DL_NUM_LANES,
    localparam int DATA_W   = LANE_W * NUM_LANES,
    localparam int CHAIN_LEN = chain_len(DL_CODE_W),
    localparam int IDX_W    = $clog2(CHAIN_LEN)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DATA_W-1:0]    din,
    input  logic [DL_CODE_W-1:0] len_code,
    input  logic                 pin_upper,
    input  logic [DATA_W-1:0]    dout,
    input  dl_ctrl_t             ctrl_q,
    input  logic [NUM_LANES-1:0][CHAIN_LEN-1:0][LANE_W-1:0] lane_stages
);

    AST_RESET_CLEARS_OUT: assert property (@(posedge clk)
        rst |=> (dout == '0 && ctrl_q == '0)); // R7

    AST_CTRL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ctrl_q == $past({pin_upper, len_code}))); // R4

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane_chk
        logic [IDX_W-1:0] sel;
        assign sel = (l == NUM_LANES - 1 && ctrl_q.pin_upper)
                   ? IDX_W'(CHAIN_LEN - 1)
                   : IDX_W'(ctrl_q.len) + IDX_W'(DL_FIRST_TAP);

        AST_LANE_TAP: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (dout[l*LANE_W +: LANE_W] == $past(lane_stages[l][sel]))); // R1

        AST_FIRST_STAGE: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (lane_stages[l][0] == $past(din[l*LANE_W +: LANE_W]))); // R6

        for (genvar s = 1; s < CHAIN_LEN; s++) begin : g_stage_chk
            AST_CHAIN_INTACT: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (lane_stages[l][s] == $past(lane_stages[l][s-1]))); // R5
        end
    end

    AST_PINNED_UPPER: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.pin_upper |=>
            (dout[DATA_W-1 -: LANE_W] == $past(lane_stages[NUM_LANES-1][CHAIN_LEN-1]))); // R3

endmodule

bind dl_delay_line dl_delay_line_chk #(
    .LANE_W    (LANE_W),
    .NUM_LANES (NUM_LANES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .din         (din),
    .len_code    (len_code),
    .pin_upper   (pin_upper),
    .dout        (dout),
    .ctrl_q      (ctrl_q),
    .lane_stages (lane_stages)
);

// File: tb/dl_delay_line_bench.sv
`timescale 1ns/1ps
module dl_delay_line_bench;

    localparam int HIST = 2048;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] din = '0;
    logic [3:0] len_code = '0;
    logic       pin_upper = 1'b0;
    logic [7:0] dout;

    int total = 0;
    int bad   = 0;
    int cyc   = -1;
    bit done  = 0;

    logic [7:0] hd [HIST];
    logic [3:0] hl [HIST];
    logic       hm [HIST];
    logic       hr [HIST];

    always #2.5 clk = ~clk;   // 200 MHz

    dl_delay_line u_dl_delay_line (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .len_code  (len_code),
        .pin_upper (pin_upper),
        .dout      (dout)
    );

    // Reference: output right after edge t, per lane.
    function automatic logic [3:0] exp_lane(int t, int lane);
        int   code;
        bit   pin;
        int   j;
        if (hr[t]) return 4'h0;
        if (t == 0 || hr[t-1]) begin
            code = 0; pin = 0;
        end else begin
            code = int'(hl[t-1]); pin = hm[t-1];
        end
        j = (lane == 1 && pin) ? 17 : code + 2;
        if (t - j < 0) return 4'h0;
        for (int k = t - j; k < t; k++) if (hr[k]) return 4'h0;
        return hd[t-j][lane*4 +: 4];
    endfunction

    task automatic step(input logic [7:0] d, input logic [3:0] l,
                        input logic m, input logic r);
        @(negedge clk);
        din = d; len_code = l; pin_upper = m; rst = r;
        @(posedge clk);
        cyc++;
        hd[cyc] = d; hl[cyc] = l; hm[cyc] = m; hr[cyc] = r;
        #1;
    endtask

    task automatic check(input string tag_lo, input string tag_hi);
        logic [3:0] e0, e1;
        e0 = exp_lane(cyc, 0);
        e1 = exp_lane(cyc, 1);
        total++;
        if (dout[3:0] !== e0) begin
            bad++;
            $display("FAIL %s cyc=%0d lower actual=%h expected=%h", tag_lo, cyc, dout[3:0], e0);
        end
        total++;
        if (dout[7:4] !== e1) begin
            bad++;
            $display("FAIL %s cyc=%0d upper actual=%h expected=%h", tag_hi, cyc, dout[7:4], e1);
        end
    endtask

    function automatic logic [7:0] pat(int n);
        return 8'((n * 37 + 11) ^ (n >> 2));
    endfunction

    task automatic t_reset();
        for (int i = 0; i < 3; i++) begin
            step(8'hFF, 4'hF, 1'b1, 1'b1);
            check("R7", "R7");
        end
    endtask

    task automatic t_sweep_shared();
        for (int c = 0; c < 16; c++)
            for (int i = 0; i < 22; i++) begin
                step(pat(cyc + i), 4'(c), 1'b0, 1'b0);
                check("R1", "R2");
            end
    endtask

    task automatic t_pinned();
        int codes [3] = '{0, 6, 15};
        foreach (codes[k])
            for (int i = 0; i < 24; i++) begin
                step(pat(cyc * 3 + i), 4'(codes[k]), 1'b1, 1'b0);
                check("R3", "R3");
            end
    endtask

    task automatic t_change_midstream();
        for (int i = 0; i < 80; i++) begin
            logic [3:0] c;
            logic       m;
            c = (i % 7 == 0) ? 4'hF : 4'((i * 5) % 16);
            m = (i % 11 < 3);
            step(pat(cyc + 100 + i), c, m, 1'b0);
            check((i % 2 == 0) ? "R4" : "R5", "R5");
        end
        for (int i = 0; i < 20; i++) begin
            step(pat(cyc + i), (i[0]) ? 4'h0 : 4'hF, 1'b0, 1'b0);
            check("R4", "R4");
        end
    endtask

    task automatic t_lane_indep();
        for (int i = 0; i < 30; i++) begin
            step({4'h0, 4'(i + 1)}, 4'd4, 1'b0, 1'b0);
            check("R6", "R6");
        end
        for (int i = 0; i < 30; i++) begin
            step({4'(15 - i), 4'h0}, 4'd9, 1'b1, 1'b0);
            check("R6", "R6");
        end
    endtask

    task automatic t_reset_mid();
        for (int i = 0; i < 10; i++) begin
            step(pat(cyc), 4'd8, 1'b0, 1'b0);
            check("R1", "R2");
        end
        step(8'hA5, 4'd8, 1'b0, 1'b1);
        check("R7", "R7");
        for (int i = 0; i < 20; i++) begin
            step(pat(cyc + 5), 4'd8, 1'b0, 1'b0);
            check("R7", "R7");
        end
    endtask

    initial begin
        t_reset();
        t_sweep_shared();
        t_pinned();
        t_change_midstream();
        t_lane_indep();
        t_reset_mid();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #500us;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired at cyc=%0d", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule